// File: doc/BRIEF.md
# Periodic Countdown Timer

This block divides an external timer clock enable into a periodic event. A reload register holds the modulus. A down-counter loads the modulus and steps toward zero once per enabled tick. When the counter arrives at zero, a sticky pending flag is set, and the interrupt line follows that flag whenever interrupts are enabled. On the next tick the counter takes the modulus again. A reload value of N therefore gives one event every N+1 ticks.

Software sets the modulus, enables the timer and enables the interrupt. It then services the event by writing a 1 to the pending bit. Writing a new modulus abandons the countdown in progress and starts again from the new value. Clearing the timer enable freezes the counter where it stands.

A small state machine sequences the counter through three states:
- `ST_HALT`: the timer is disabled.
- `ST_RUN`: the count is non-zero and decrementing.
- `ST_WRAP`: the count sits at zero and waits for the tick that reloads it.

Its transitions are:
- `HALT→RUN` / `HALT→WRAP`: the enable rises (and any tick in that cycle is honoured).
- `RUN→WRAP`: a tick is taken at count 1.
- `WRAP→RUN`: a tick reloads a non-zero modulus.
- `WRAP→WRAP`: a tick reloads a zero modulus.
- any `→HALT`: the enable is clear.
- any state on a reload write: goes to `RUN`, `WRAP` or `HALT` according to the written value and the enable.

Top module: `periodic_timer`

## Requirements
- R1: After reset the reload register reads all ones and the count reads all ones. The control/status register reads 0, and `irq` is 0.
- R2: With the timer enabled, each cycle with `tick`=1 lowers the count by exactly one, and cycles with `tick`=0 leave it unchanged.
- R3: A tick that brings the count to zero sets the pending bit, which is control/status bit 0. A non-zero reload value N gives a zero event every N+1 ticks.
- R4: A tick taken while the count is zero loads the count from the reload register.
- R5: A write to the reload register (address 0) sets the count to the written value on the next cycle. The write wins over a tick in the same cycle, and the write itself sets no pending bit.
- R6: The pending bit stays 1 through further zero events. Writing 1 to control/status bit 0 (address 1) clears it, and writing 0 there leaves it unchanged.
- R7: When a clear of the pending bit and a zero event fall in the same cycle, the pending bit ends at 1.
- R8: `irq` equals the pending bit AND the interrupt-enable bit (control/status bit 1).
- R9: While the timer-enable bit (control/status bit 2) is 0, ticks leave the count unchanged. Counting resumes from the held value when the bit is set again.
- R10: A reload value of zero sets the pending bit on every enabled tick.
- R11: Reads have no effect on any state. A write to the count address (2) changes nothing. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer clock enable, one count step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 reload, 1 control/status, 2 count (ignored) |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address: 0 reload, 1 control/status, 2 count, 3 zero |
| rd_data | output | CNT_W | Read data, combinational from the register state |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the timer with `CNT_W` = 4, so that every possible modulus from 0 to 15 can be swept. For each modulus it runs two full periods. The expected count and pending state after each tick come from a closed-form expression in the tick number. The narrow counter brings the all-ones reset value, the zero modulus and the reload at wrap within a few cycles. Directed sequences then cover the write-versus-tick and clear-versus-event collisions, freezing, and interrupt gating.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1,
        ST_WRAP = 2'd2
    } run_state_e;

    localparam int BIT_PEND = 0;
    localparam int BIT_IE   = 1;
    localparam int BIT_TE   = 2;
    localparam int CTRL_W   = 3;

endpackage

// File: rtl/ptmr_ctrl_regs.sv
module ptmr_ctrl_regs
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             zero_evt,
    output logic [CNT_W-1:0] reload,
    output logic             irq_en,
    output logic             tmr_en,
    output logic             pend,
    output logic             reload_wr
);

    logic ctrl_wr;
    logic clr_req;

    assign reload_wr = wr_en && (reg_sel_e'(wr_addr) == SEL_RELOAD);
    assign ctrl_wr   = wr_en && (reg_sel_e'(wr_addr) == SEL_CTRL);
    assign clr_req   = ctrl_wr && wr_data[BIT_PEND];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload <= '1;
            irq_en <= 1'b0;
            tmr_en <= 1'b0;
        end else begin
            if (reload_wr) begin
                reload <= wr_data;
            end
            if (ctrl_wr) begin
                irq_en <= wr_data[BIT_IE];
                tmr_en <= wr_data[BIT_TE];
            end
        end
    end

    // Pending flag: a zero event has priority over a software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (zero_evt) begin
            pend <= 1'b1;
        end else if (clr_req) begin
            pend <= 1'b0;
        end
    end

    a_r6_sticky_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr_req) |=> pend);

    a_r7_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> pend);

    a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !zero_evt) |=> !pend);

    a_r5_reload_capture: assert property (@(posedge clk) disable iff (!rst_n)
        reload_wr |=> (reload == $past(wr_data)));

endmodule

// File: rtl/ptmr_count_fsm.sv
module ptmr_count_fsm
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             tmr_en,
    input  logic [CNT_W-1:0] reload,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             zero_evt
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    run_state_e       st_q, st_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic [CNT_W-1:0] step_val;

    // State and counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_HALT;
            cnt_q <= '1;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
        end
    end

    // Next state, next count and the zero event
    always_comb begin
        st_nx    = st_q;
        cnt_nx   = cnt_q;
        zero_evt = 1'b0;
        step_val = (cnt_q == ZERO) ? reload : (cnt_q - ONE);
        if (reload_wr) begin
            cnt_nx = wr_data;
            if (!tmr_en) begin
                st_nx = ST_HALT;
            end else if (wr_data == ZERO) begin
                st_nx = ST_WRAP;
            end else begin
                st_nx = ST_RUN;
            end
        end else begin
            unique case (st_q)
                ST_HALT: begin
                    if (tmr_en) begin
                        if (tick) begin
                            cnt_nx   = step_val;
                            zero_evt = (step_val == ZERO);
                            st_nx    = (step_val == ZERO) ? ST_WRAP : ST_RUN;
                        end else begin
                            st_nx = (cnt_q == ZERO) ? ST_WRAP : ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (!tmr_en) begin
                        st_nx = ST_HALT;
                    end else if (tick) begin
                        cnt_nx = cnt_q - ONE;
                        if (cnt_q == ONE) begin
                            zero_evt = 1'b1;
                            st_nx    = ST_WRAP;
                        end
                    end
                end
                ST_WRAP: begin
                    if (!tmr_en) begin
                        st_nx = ST_HALT;
                    end else if (tick) begin
                        cnt_nx = reload;
                        if (reload == ZERO) begin
                            zero_evt = 1'b1;
                        end else begin
                            st_nx = ST_RUN;
                        end
                    end
                end
                default: begin
                    st_nx = ST_HALT;
                end
            endcase
        end
    end

    assign count = cnt_q;

    a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_en && tick && !reload_wr && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - ONE));

    a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !reload_wr) |=> $stable(cnt_q));

    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_en && !reload_wr) |=> $stable(cnt_q));

    a_r4_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_en && tick && !reload_wr && cnt_q == ZERO) |=> (cnt_q == $past(reload)));

    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        reload_wr |=> (cnt_q == $past(wr_data)));

    a_r3_wrap_means_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WRAP) |-> (cnt_q == ZERO));

    a_r3_run_means_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |-> (cnt_q != ZERO));

endmodule

// File: rtl/ptmr_read_mux.sv
module ptmr_read_mux
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [1:0]       rd_addr,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] count,
    input  logic             pend,
    input  logic             irq_en,
    input  logic             tmr_en,
    output logic [CNT_W-1:0] rd_data
);

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_addr))
            SEL_RELOAD: rd_data = reload;
            SEL_COUNT:  rd_data = count;
            SEL_CTRL: begin
                rd_data[BIT_PEND] = pend;
                rd_data[BIT_IE]   = irq_en;
                rd_data[BIT_TE]   = tmr_en;
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/periodic_timer.sv
module periodic_timer
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);

    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             irq_en;
    logic             tmr_en;
    logic             pend;
    logic             reload_wr;
    logic             zero_evt;

    ptmr_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .zero_evt  (zero_evt),
        .reload    (reload),
        .irq_en    (irq_en),
        .tmr_en    (tmr_en),
        .pend      (pend),
        .reload_wr (reload_wr)
    );

    ptmr_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .tmr_en    (tmr_en),
        .reload    (reload),
        .reload_wr (reload_wr),
        .wr_data   (wr_data),
        .count     (count),
        .zero_evt  (zero_evt)
    );

    ptmr_read_mux #(.CNT_W(CNT_W)) u_rd (
        .rd_addr (rd_addr),
        .reload  (reload),
        .count   (count),
        .pend    (pend),
        .irq_en  (irq_en),
        .tmr_en  (tmr_en),
        .rd_data (rd_data)
    );

    assign irq = pend & irq_en;

    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);

    a_r10_zero_modulus: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_en && tick && !reload_wr && count == '0 && reload == '0) |=> (irq == irq_en));

    initial begin
        a_width_ok: assert (CNT_W >= CTRL_W);
    end

endmodule

// File: tb/periodic_timer_test.sv
module periodic_timer_test;

    localparam int W          = 4;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_RELOAD = 2'd0;
    localparam logic [1:0] A_CTRL   = 2'd1;
    localparam logic [1:0] A_COUNT  = 2'd2;
    localparam logic [1:0] A_NONE   = 2'd3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = 2'd0;
    logic [W-1:0] rd_data;
    logic         irq;

    int checks = 0;
    int errors = 0;

    periodic_timer #(.CNT_W(W)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq     (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    function automatic int cv(input int te, input int ie, input int clr);
        return (te << 2) | (ie << 1) | clr;
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v;
        int cnt0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(A_RELOAD, v); chk("R1 reload", v, 15);
        rd(A_COUNT, v);  chk("R1 count", v, 15);
        rd(A_CTRL, v);   chk("R1 ctrl", v, 0);
        chk("R1 irq", int'(irq), 0);

        // R3 R4 R6 R10: sweep every modulus over two periods
        for (int r = 0; r < 16; r++) begin
            wr(A_CTRL, cv(0, 1, 1));
            wr(A_RELOAD, r);
            rd(A_COUNT, v); chk("R5 load", v, r);
            wr(A_CTRL, cv(1, 1, 0));
            for (int k = 1; k <= 2 * (r + 1); k++) begin
                step();
                rd(A_COUNT, v);
                chk("R2/R4 count", v, r - (k % (r + 1)));
                rd(A_CTRL, v);
                chk("R3/R6/R10 pend", v & 1, (k >= r) ? 1 : 0);
                chk("R8 irq", int'(irq), (k >= r) ? 1 : 0);
            end
        end

        // R2 idle cycles leave count alone
        wr(A_CTRL, cv(1, 0, 1));
        wr(A_RELOAD, 5);
        repeat (4) @(negedge clk);
        rd(A_COUNT, v); chk("R2 no tick", v, 5);

        // R9 freeze and resume
        step(); step();
        rd(A_COUNT, v); chk("R2 two ticks", v, 3);
        wr(A_CTRL, cv(0, 0, 0));
        step(); step(); step();
        rd(A_COUNT, v); chk("R9 frozen", v, 3);
        wr(A_CTRL, cv(1, 0, 0));
        step();
        rd(A_COUNT, v); chk("R9 resume", v, 2);

        // R5 write beats a same-cycle tick, no event
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_RELOAD; wr_data = W'(9); tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd(A_COUNT, v); chk("R5 write wins", v, 9);
        rd(A_CTRL, v);  chk("R5 no event", v & 1, 0);

        // R5 / R10 write zero while enabled
        wr(A_RELOAD, 0);
        rd(A_CTRL, v); chk("R5 zero write no event", v & 1, 0);
        step();
        rd(A_CTRL, v); chk("R10 zero modulus event", v & 1, 1);

        // R6 write 0 keeps, write 1 clears
        wr(A_CTRL, cv(1, 0, 0));
        rd(A_CTRL, v); chk("R6 write0 keeps", v & 1, 1);
        wr(A_CTRL, cv(0, 0, 1));
        rd(A_CTRL, v); chk("R6 w1c", v & 1, 0);

        // R7 clear and event in the same cycle
        wr(A_RELOAD, 2);
        wr(A_CTRL, cv(1, 0, 0));
        step();
        rd(A_COUNT, v); chk("R7 setup", v, 1);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_CTRL; wr_data = W'(cv(1, 0, 1)); tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd(A_CTRL, v); chk("R7 event wins", v & 1, 1);

        // R8 irq gating
        chk("R8 masked", int'(irq), 0);
        wr(A_CTRL, cv(0, 1, 0));
        chk("R8 unmasked", int'(irq), 1);

        // R11 reads and count-address writes have no effect
        rd(A_COUNT, cnt0);
        for (int i = 0; i < 6; i++) begin
            rd(A_CTRL, v);
            rd(A_COUNT, v);
            @(negedge clk);
        end
        rd(A_CTRL, v);  chk("R11 pend after reads", v & 1, 1);
        rd(A_COUNT, v); chk("R11 count after reads", v, cnt0);
        wr(A_COUNT, 7);
        rd(A_COUNT, v);  chk("R11 count write ignored", v, cnt0);
        rd(A_RELOAD, v); chk("R11 reload untouched", v, 2);
        rd(A_CTRL, v);   chk("R11 ctrl untouched", v, cv(0, 1, 1));
        rd(A_NONE, v);   chk("R11 unused address", v, 0);

        finish_run();
    end

endmodule